// File: doc/BRIEF.md
# Instruction Window Hazard Classifier

This block inspects a short run of decoded instructions held in program order and reports every register hazard between them. Each window slot carries a valid bit, one destination register specifier and a configurable number of source specifiers. Each source has its own enable bit. A source slot that holds an immediate constant is marked disabled, so it can never produce a hazard.

For each ordered pair of slots, with the older instruction at the lower index i and the younger at the higher index j, three kinds of hazard are classified. A true (read-after-write) hazard means the younger reads what the older writes. An anti (write-after-read) hazard means the younger writes what the older reads. An output (write-after-write) hazard means both write the same register. The results come out as three flag matrices plus one per-slot summary bit.

The window is presented on a parallel load port and captured with a load strobe. The flags appear in registers one clock after the strobe edge. The block only reports hazards and takes no action on them.

Top module: `hazard_window`

## Requirements
- R1: A true hazard flag for pair (i,j), i<j, is set when the destination of slot i equals an enabled source of slot j. It is reported in `raw_flags` bit j*DEPTH+i.
- R2: An anti hazard flag for pair (i,j), i<j, is set when an enabled source of slot i equals the destination of slot j. It is reported in `war_flags` bit j*DEPTH+i.
- R3: An output hazard flag for pair (i,j), i<j, is set when the destinations of slots i and j are equal. It is reported in `waw_flags` bit j*DEPTH+i.
- R4: A source whose enable bit is 0 (for example, an immediate operand) takes part in no comparison.
- R5: A slot whose valid bit is 0 produces no flag in any matrix, whether it is the older or the younger member of the pair.
- R6: Only pairs with the older slot at the lower index are reported. Every matrix bit j*DEPTH+i with i>=j is always 0, so a lower-index reader and a higher-index writer give an anti hazard and never a true hazard.
- R7: `dep_any` bit j is 1 exactly when some i<j has any of the three flags set for pair (i,j).
- R8: All outputs update at the first rising edge where `ld_stb` is 1, using the port values at that edge. While `ld_stb` is 0, the outputs hold.
- R9: A synchronous active-high `rst` clears every output at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_stb | input | 1 | Capture strobe for the window |
| win_valid | input | DEPTH | Slot valid bits, bit k for slot k |
| win_dst | input | DEPTH*REG_W | Destination of slot k at bits [k*REG_W +: REG_W] |
| win_src | input | DEPTH*NSRC*REG_W | Source s of slot k at bits [(k*NSRC+s)*REG_W +: REG_W] |
| win_src_en | input | DEPTH*NSRC | Enable of source s of slot k at bit k*NSRC+s |
| raw_flags | output | DEPTH*DEPTH | True hazard matrix, bit j*DEPTH+i |
| war_flags | output | DEPTH*DEPTH | Anti hazard matrix, bit j*DEPTH+i |
| waw_flags | output | DEPTH*DEPTH | Output hazard matrix, bit j*DEPTH+i |
| dep_any | output | DEPTH | Per-slot summary of hazards on older slots |

## Verification
The properties assume that `rst` and `ld_stb` are driven to known levels at every rising edge and that window fields are steady around the edge where the strobe is high. They place no constraint on register values. Stimulus changes inputs only on the falling edge. Random windows draw specifiers from a narrow range of eight registers so that hazard pairs of all three kinds occur often. Directed windows start from a background of unique specifiers, so that exactly one chosen collision is present.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

    // Default geometry of the window
    localparam int DEF_DEPTH = 4;
    localparam int DEF_REG_W = 5;
    localparam int DEF_NSRC  = 2;

    // Index of each hazard kind inside a flag vector
    typedef enum logic [1:0] {
        HZ_TRUE   = 2'd0,
        HZ_ANTI   = 2'd1,
        HZ_OUTPUT = 2'd2
    } hz_kind_e;

    // Classification result for one older/younger pair
    typedef struct packed {
        logic waw;
        logic war;
        logic raw;
    } hz_flags_t;

    localparam hz_flags_t HZ_NONE = '{waw: 1'b0, war: 1'b0, raw: 1'b0};

    function automatic logic hz_any(input hz_flags_t f);
        return f.raw | f.war | f.waw;
    endfunction

    function automatic logic hz_pick(input hz_flags_t f, input hz_kind_e k);
        case (k)
            HZ_TRUE:   return f.raw;
            HZ_ANTI:   return f.war;
            HZ_OUTPUT: return f.waw;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/hazard_pair_cmp.sv
module hazard_pair_cmp
    import hazard_pkg::*;
#(
    parameter int REG_W = DEF_REG_W,
    parameter int NSRC  = DEF_NSRC
) (
    input  logic                  old_vld,
    input  logic [REG_W-1:0]      old_dst,
    input  logic [NSRC*REG_W-1:0] old_src,
    input  logic [NSRC-1:0]       old_src_en,
    input  logic                  yng_vld,
    input  logic [REG_W-1:0]      yng_dst,
    input  logic [NSRC*REG_W-1:0] yng_src,
    input  logic [NSRC-1:0]       yng_src_en,
    output hz_flags_t             flags
);

    logic [NSRC-1:0] yng_reads_old;   // younger source hits older destination
    logic [NSRC-1:0] old_reads_yng;   // older source hits younger destination
    logic            both_vld;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        assign yng_reads_old[s] = yng_src_en[s] &&
                                  (yng_src[s*REG_W +: REG_W] == old_dst);
        assign old_reads_yng[s] = old_src_en[s] &&
                                  (old_src[s*REG_W +: REG_W] == yng_dst);
    end

    assign both_vld = old_vld & yng_vld;

    always_comb begin
        flags     = HZ_NONE;
        flags.raw = both_vld & (|yng_reads_old);
        flags.war = both_vld & (|old_reads_yng);
        flags.waw = both_vld & (old_dst == yng_dst);
    end

endmodule

// File: rtl/hazard_summary.sv
module hazard_summary #(
    parameter int DEPTH = hazard_pkg::DEF_DEPTH
) (
    input  logic [DEPTH*DEPTH-1:0] any_mat,
    output logic [DEPTH-1:0]       dep_vec
);

    // Row j holds the pairs whose younger member is slot j
    for (genvar j = 0; j < DEPTH; j++) begin : g_row
        assign dep_vec[j] = |any_mat[j*DEPTH +: DEPTH];
    end

endmodule

// File: rtl/hazard_window.sv
module hazard_window
    import hazard_pkg::*;
#(
    parameter int DEPTH = DEF_DEPTH,
    parameter int REG_W = DEF_REG_W,
    parameter int NSRC  = DEF_NSRC
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        ld_stb,
    input  logic [DEPTH-1:0]            win_valid,
    input  logic [DEPTH*REG_W-1:0]      win_dst,
    input  logic [DEPTH*NSRC*REG_W-1:0] win_src,
    input  logic [DEPTH*NSRC-1:0]       win_src_en,
    output logic [DEPTH*DEPTH-1:0]      raw_flags,
    output logic [DEPTH*DEPTH-1:0]      war_flags,
    output logic [DEPTH*DEPTH-1:0]      waw_flags,
    output logic [DEPTH-1:0]            dep_any
);

    localparam int NPAIR_BITS = DEPTH * DEPTH;
    localparam int SLOT_SRC_W = NSRC * REG_W;

    // Bits whose older index is not below the younger index
    function automatic logic [NPAIR_BITS-1:0] upper_mask();
        logic [NPAIR_BITS-1:0] m;
        m = '0;
        for (int j = 0; j < DEPTH; j++)
            for (int i = 0; i < DEPTH; i++)
                if (i >= j) m[j*DEPTH+i] = 1'b1;
        return m;
    endfunction

    // All pair bits that involve slot k in either role
    function automatic logic [NPAIR_BITS-1:0] slot_mask(input int k);
        logic [NPAIR_BITS-1:0] m;
        m = '0;
        for (int n = 0; n < DEPTH; n++) begin
            m[k*DEPTH+n] = 1'b1;
            m[n*DEPTH+k] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [NPAIR_BITS-1:0] NOT_PAIR = upper_mask();

    hz_flags_t                pair_flags [NPAIR_BITS];
    logic [NPAIR_BITS-1:0]    raw_d, war_d, waw_d, any_d;
    logic [DEPTH-1:0]         dep_d;
    logic [NPAIR_BITS-1:0]    raw_q, war_q, waw_q;
    logic [DEPTH-1:0]         dep_q;

    // Pair comparators: one per older/younger pair
    for (genvar j = 0; j < DEPTH; j++) begin : g_yng
        for (genvar i = 0; i < DEPTH; i++) begin : g_old
            if (i < j) begin : g_cmp
                hazard_pair_cmp #(
                    .REG_W (REG_W),
                    .NSRC  (NSRC)
                ) u_cmp (
                    .old_vld    (win_valid[i]),
                    .old_dst    (win_dst[i*REG_W +: REG_W]),
                    .old_src    (win_src[i*SLOT_SRC_W +: SLOT_SRC_W]),
                    .old_src_en (win_src_en[i*NSRC +: NSRC]),
                    .yng_vld    (win_valid[j]),
                    .yng_dst    (win_dst[j*REG_W +: REG_W]),
                    .yng_src    (win_src[j*SLOT_SRC_W +: SLOT_SRC_W]),
                    .yng_src_en (win_src_en[j*NSRC +: NSRC]),
                    .flags      (pair_flags[j*DEPTH+i])
                );

                // R3: equal destinations on a valid pair give an output hazard
                p_waw_pair_r3: assert property (@(posedge clk) disable iff (rst)
                    (ld_stb && win_valid[i] && win_valid[j] &&
                     win_dst[i*REG_W +: REG_W] == win_dst[j*REG_W +: REG_W])
                    |=> waw_flags[j*DEPTH+i]);
            end else begin : g_none
                assign pair_flags[j*DEPTH+i] = HZ_NONE;
            end
        end
    end

    // Spread the pair structs into per-kind matrices
    always_comb begin
        for (int b = 0; b < NPAIR_BITS; b++) begin
            raw_d[b] = hz_pick(pair_flags[b], HZ_TRUE);
            war_d[b] = hz_pick(pair_flags[b], HZ_ANTI);
            waw_d[b] = hz_pick(pair_flags[b], HZ_OUTPUT);
            any_d[b] = hz_any(pair_flags[b]);
        end
    end

    hazard_summary #(
        .DEPTH (DEPTH)
    ) u_sum (
        .any_mat (any_d),
        .dep_vec (dep_d)
    );

    // Result registers
    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q <= '0;
            war_q <= '0;
            waw_q <= '0;
            dep_q <= '0;
        end else if (ld_stb) begin
            raw_q <= raw_d;
            war_q <= war_d;
            waw_q <= waw_d;
            dep_q <= dep_d;
        end
    end

    assign raw_flags = raw_q;
    assign war_flags = war_q;
    assign waw_flags = waw_q;
    assign dep_any   = dep_q;

    // R6: no flag ever sits on a bit with i >= j
    p_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
        ((raw_q | war_q | waw_q) & NOT_PAIR) == '0);

    // R8: without a strobe every output holds
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !ld_stb |=> ($stable(raw_q) && $stable(war_q) &&
                     $stable(waw_q) && $stable(dep_q)));

    // R9: reset clears every output
    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (raw_q == '0 && war_q == '0 && waw_q == '0 && dep_q == '0));

    for (genvar k = 0; k < DEPTH; k++) begin : g_chk
        // R5: an invalid slot yields no flag in its row or column
        p_invalid_slot_r5: assert property (@(posedge clk) disable iff (rst)
            (ld_stb && !win_valid[k])
            |=> (((raw_q | war_q | waw_q) & slot_mask(k)) == '0));

        // R7: summary bit agrees with its row of registered flags
        p_summary_r7: assert property (@(posedge clk) disable iff (rst)
            dep_q[k] == (|((raw_q | war_q | waw_q) >> (k*DEPTH) &
                           {{(NPAIR_BITS-DEPTH){1'b0}}, {DEPTH{1'b1}}})));
    end

endmodule

// File: tb/sim_hazard_window.sv
`timescale 1ns/1ps
module sim_hazard_window;

    localparam int D  = 4;
    localparam int RW = 5;
    localparam int NS = 2;
    localparam int NB = D * D;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ld_stb = 1'b0;
    logic [D-1:0]       win_valid = '0;
    logic [D*RW-1:0]    win_dst = '0;
    logic [D*NS*RW-1:0] win_src = '0;
    logic [D*NS-1:0]    win_src_en = '0;
    logic [NB-1:0]      raw_flags, war_flags, waw_flags;
    logic [D-1:0]       dep_any;

    always #2.5 clk = ~clk;

    hazard_window #(.DEPTH(D), .REG_W(RW), .NSRC(NS)) u0 (
        .clk(clk), .rst(rst), .ld_stb(ld_stb),
        .win_valid(win_valid), .win_dst(win_dst),
        .win_src(win_src), .win_src_en(win_src_en),
        .raw_flags(raw_flags), .war_flags(war_flags),
        .waw_flags(waw_flags), .dep_any(dep_any)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // Bench copy of the window
    logic [RW-1:0] b_dst [D];
    logic [RW-1:0] b_src [D][NS];
    logic          b_en  [D][NS];
    logic          b_v   [D];

    logic [NB-1:0] e_raw, e_war, e_waw;
    logic [D-1:0]  e_dep;

    task automatic chk(input string tag, input logic [NB-1:0] act,
                       input logic [NB-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected flags from the requirement text
    task automatic model();
        e_raw = '0; e_war = '0; e_waw = '0; e_dep = '0;
        for (int j = 0; j < D; j++)
            for (int i = 0; i < j; i++)
                if (b_v[i] && b_v[j]) begin
                    for (int s = 0; s < NS; s++) begin
                        if (b_en[j][s] && b_src[j][s] == b_dst[i]) e_raw[j*D+i] = 1'b1;
                        if (b_en[i][s] && b_src[i][s] == b_dst[j]) e_war[j*D+i] = 1'b1;
                    end
                    if (b_dst[i] == b_dst[j]) e_waw[j*D+i] = 1'b1;
                end
        for (int j = 0; j < D; j++)
            for (int i = 0; i < j; i++)
                if (e_raw[j*D+i] || e_war[j*D+i] || e_waw[j*D+i]) e_dep[j] = 1'b1;
    endtask

    task automatic pack();
        for (int k = 0; k < D; k++) begin
            win_valid[k] = b_v[k];
            win_dst[k*RW +: RW] = b_dst[k];
            for (int s = 0; s < NS; s++) begin
                win_src[(k*NS+s)*RW +: RW] = b_src[k][s];
                win_src_en[k*NS+s] = b_en[k][s];
            end
        end
    endtask

    // Unique specifiers: no hazards at all
    task automatic background();
        for (int k = 0; k < D; k++) begin
            b_v[k] = 1'b1;
            b_dst[k] = RW'(20 + k);
            for (int s = 0; s < NS; s++) begin
                b_src[k][s] = RW'(10 + 2*k + s);
                b_en[k][s] = 1'b1;
            end
        end
    endtask

    // Drive at falling edge, capture at rising edge, sample at next falling edge
    task automatic load();
        pack();
        ld_stb = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ld_stb = 1'b0;
    endtask

    task automatic check_all(input string tag);
        model();
        chk({tag, " R1 raw"}, raw_flags, e_raw);
        chk({tag, " R2 war"}, war_flags, e_war);
        chk({tag, " R3 waw"}, waw_flags, e_waw);
        chk({tag, " R7 dep"}, NB'(dep_any), NB'(e_dep));
    endtask

    initial begin
        #(5.0 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int seed;
        logic [NB-1:0] keep_raw, keep_war, keep_waw;
        seed = $urandom(32'h5eed_0042);
        background();
        pack();
        @(negedge clk);
        @(negedge clk);
        // R9: reset state
        chk("R9 reset raw", raw_flags, '0);
        chk("R9 reset war", war_flags, '0);
        chk("R9 reset waw", waw_flags, '0);
        chk("R9 reset dep", NB'(dep_any), '0);
        rst = 1'b0;
        @(negedge clk);

        // R1: slot0 writes r3, slot2 reads r3
        background(); b_dst[0] = 5'd3; b_src[2][0] = 5'd3; load();
        chk("R1 directed raw", raw_flags, NB'(1) << (2*D+0));
        check_all("R1 directed");

        // R2: slot1 reads r9, slot3 writes r9
        background(); b_src[1][1] = 5'd9; b_dst[3] = 5'd9; load();
        chk("R2 directed war", war_flags, NB'(1) << (3*D+1));
        check_all("R2 directed");

        // R3: slots 0 and 3 write r7
        background(); b_dst[0] = 5'd7; b_dst[3] = 5'd7; load();
        chk("R3 directed waw", waw_flags, NB'(1) << (3*D+0));
        check_all("R3 directed");

        // R4: matching source disabled (immediate operand)
        background(); b_dst[0] = 5'd3; b_src[2][0] = 5'd3; b_en[2][0] = 1'b0; load();
        chk("R4 disabled source raw", raw_flags, '0);
        chk("R4 disabled source dep", NB'(dep_any), '0);

        // R5: invalid younger and invalid older slot
        background(); b_dst[0] = 5'd7; b_dst[3] = 5'd7; b_v[3] = 1'b0; load();
        chk("R5 invalid younger waw", waw_flags, '0);
        background(); b_dst[1] = 5'd2; b_src[2][1] = 5'd2; b_v[1] = 1'b0; load();
        chk("R5 invalid older raw", raw_flags, '0);

        // R6: lower index reads, higher index writes -> anti only
        background(); b_src[1][0] = 5'd4; b_dst[2] = 5'd4; load();
        chk("R6 order raw", raw_flags, '0);
        chk("R6 order war", war_flags, NB'(1) << (2*D+1));

        // R7: summary on slot 3 only
        background(); b_dst[2] = 5'd1; b_src[3][1] = 5'd1; load();
        chk("R7 summary", NB'(dep_any), NB'(4'b1000));

        // R8: hold without strobe
        keep_raw = raw_flags; keep_war = war_flags; keep_waw = waw_flags;
        background(); b_dst[0] = 5'd6; b_dst[1] = 5'd6; b_src[3][0] = 5'd6; pack();
        @(negedge clk); @(negedge clk);
        chk("R8 hold raw", raw_flags, keep_raw);
        chk("R8 hold war", war_flags, keep_war);
        chk("R8 hold waw", waw_flags, keep_waw);
        load();
        check_all("R8 after strobe");

        // Random windows with a narrow register range
        for (int t = 0; t < 400; t++) begin
            for (int k = 0; k < D; k++) begin
                b_v[k] = ($urandom % 8) != 0;
                b_dst[k] = RW'($urandom % 8);
                for (int s = 0; s < NS; s++) begin
                    b_src[k][s] = RW'($urandom % 8);
                    b_en[k][s] = ($urandom % 4) != 0;
                end
            end
            load();
            check_all("random");
        end

        // R9: reset mid-run clears flags
        background(); b_dst[0] = 5'd5; b_dst[1] = 5'd5; load();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R9 mid reset waw", waw_flags, '0);
        chk("R9 mid reset dep", NB'(dep_any), '0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule